// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a virtual page number into a physical page number by reading four levels of page maps held in main memory. A translation cache sends it a request carrying the virtual page number, the access mode and the physical page number of the top-level map. The walker then reads one 8-byte entry per level over a simple read port. Each entry is read at the address formed from the page number in the entry before it and a 9-bit slice of the virtual page number.

At each level the walker checks the present bit. A missing entry ends the walk at once with a page fault. Along the path it gathers the write-permission and user-permission bits. A walk that completes returns the leaf's physical page number, a read-only flag that is set when any level forbids writes, and a user flag that is set only when every level allows user access. A user-mode request that ends on a page closed to user mode is reported as a fault. One walk runs at a time, and a new request is taken only while the walker is idle.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held, and in the cycle after it is released, req_ready is 1 and both mem_req_valid and rsp_valid are 0. A reset in the middle of a walk abandons it and produces no response.
- R2: A request is accepted only in a cycle where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until the walk has finished. req_valid, req_vpn, req_user and req_root_ppn are ignored while req_ready is 0.
- R3: Read k, counted from 0, is issued at address {P_k, I_k, 3'b000}. P_0 is req_root_ppn. P_(k+1) is bits [51:12] of the entry returned by read k. I_0..I_3 are req_vpn bits [35:27], [26:18], [17:9] and [8:0], which are virtual address bits [47:39], [38:30], [29:21] and [20:12].
- R4: Each read is a one-cycle pulse of mem_req_valid. The next read is issued only after the data of the previous read has come back on mem_rsp_valid. A walk whose entries are all present makes exactly 4 reads.
- R5: Entry bit 0 is the present bit. An entry with bit 0 at 0 ends the walk at that level with rsp_fault=1, and no further read is made, so a fault at level k costs k+1 reads.
- R6: Entry bit 1 is the write permission. After a walk without a fault, rsp_readonly is 1 exactly when bit 1 was 0 in at least one of the four entries.
- R7: Entry bit 2 is the user permission. rsp_user is the AND of bit 2 over the four entries. When req_user=1 and rsp_user would be 0, the walk makes all four reads and then reports rsp_fault=1. A request with req_user=0 never faults on bit 2.
- R8: After a walk without a fault, rsp_ppn equals bits [51:12] of the level-3 entry.
- R9: rsp_valid is a one-cycle pulse per walk. In the next cycle req_ready is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vpn | input | 36 | Virtual page number (virtual address bits [47:12]) |
| req_user | input | 1 | 1 for a user-mode access, 0 for kernel mode |
| req_root_ppn | input | 40 | Physical page number of the top-level map |
| mem_req_valid | output | 1 | One-cycle pulse: read one entry |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry data valid (at least one cycle after the request) |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | One-cycle pulse: walk result present |
| rsp_ppn | output | 40 | Translated physical page number |
| rsp_readonly | output | 1 | Some level on the path forbids writes |
| rsp_user | output | 1 | Every level on the path allows user access |
| rsp_fault | output | 1 | Page fault (entry not present, or user access to a kernel page) |

## Verification
A wrong level counter or index select shows on the very next read as an entry address that differs from the one the bench forms. The bench compares every read address, so a fault in the datapath is caught within one memory round trip, not at the end of the walk. A stuck or misrouted state machine shows as a wrong read count, a missing or doubled result pulse, or req_ready not coming back in the cycle after the result. These appear at the close of the walk in which the error happens. A flaw in the gathered permissions shows only in the result flags of walks whose entries mix set and clear bits, so the vectors place clear bits at different levels.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int LEVELS   = 4;
  localparam int IDX_W    = 9;
  localparam int OFF_W    = 12;
  localparam int PPN_W    = 40;
  localparam int ENTRY_W  = 64;
  localparam int VPN_W    = LEVELS * IDX_W;
  localparam int PA_W     = PPN_W + OFF_W;
  localparam int LVL_W    = $clog2(LEVELS);
  localparam int ENT_SH   = $clog2(ENTRY_W / 8);

  // entry field positions
  localparam int B_PRES   = 0;
  localparam int B_WRITE  = 1;
  localparam int B_USER   = 2;
  localparam int B_PPN_LO = OFF_W;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2,
    S_DONE = 2'd3
  } walk_state_t;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int LEVELS = pgwalk_pkg::LEVELS,
  parameter int IDX_W  = pgwalk_pkg::IDX_W,
  parameter int PPN_W  = pgwalk_pkg::PPN_W,
  parameter int ENT_SH = pgwalk_pkg::ENT_SH,
  localparam int VPN_W = LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS),
  localparam int PA_W  = PPN_W + IDX_W + ENT_SH
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [LVL_W-1:0] level,
  input  logic [PPN_W-1:0] table_ppn,
  output logic [PA_W-1:0]  entry_addr
);
  logic [IDX_W-1:0] idx [LEVELS];

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign entry_addr = {table_ppn, idx[level], {ENT_SH{1'b0}}};
endmodule

// File: rtl/pgwalk_attr.sv
module pgwalk_attr #(
  parameter int ENTRY_W  = pgwalk_pkg::ENTRY_W,
  parameter int PPN_W    = pgwalk_pkg::PPN_W,
  parameter int B_PRES   = pgwalk_pkg::B_PRES,
  parameter int B_WRITE  = pgwalk_pkg::B_WRITE,
  parameter int B_USER   = pgwalk_pkg::B_USER,
  parameter int B_PPN_LO = pgwalk_pkg::B_PPN_LO
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               load,
  input  logic [ENTRY_W-1:0] entry,
  output logic               present,
  output logic [PPN_W-1:0]   next_ppn,
  output logic               ro_now,
  output logic               usr_now
);
  logic ro_acc, usr_acc;

  assign present  = entry[B_PRES];
  assign next_ppn = entry[B_PPN_LO +: PPN_W];
  assign ro_now   = ro_acc | ~entry[B_WRITE];
  assign usr_now  = usr_acc & entry[B_USER];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      ro_acc  <= 1'b0;
      usr_acc <= 1'b1;
    end else if (load) begin
      ro_acc  <= ro_now;
      usr_acc <= usr_now;
    end
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl #(
  parameter int LEVELS = pgwalk_pkg::LEVELS,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             mem_rsp_valid,
  input  logic             present,
  output logic             idle,
  output logic             start,
  output logic             issue,
  output logic             take,
  output logic             finish,
  output logic             done,
  output logic [LVL_W-1:0] level
);
  import pgwalk_pkg::*;

  walk_state_t state;
  logic        last;

  assign idle   = (state == S_IDLE);
  assign issue  = (state == S_REQ);
  assign done   = (state == S_DONE);
  assign start  = idle && req_valid;
  assign take   = (state == S_WAIT) && mem_rsp_valid;
  assign last   = (level == LVL_W'(LEVELS - 1));
  assign finish = take && (!present || last);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      level <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          state <= S_REQ;
          level <= '0;
        end
        S_REQ:  state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (!present || last) begin
            state <= S_DONE;
          end else begin
            state <= S_REQ;
            level <= level + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int LEVELS  = pgwalk_pkg::LEVELS,
  parameter int IDX_W   = pgwalk_pkg::IDX_W,
  parameter int PPN_W   = pgwalk_pkg::PPN_W,
  parameter int ENTRY_W = pgwalk_pkg::ENTRY_W,
  localparam int VPN_W  = LEVELS * IDX_W,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int ENT_SH = $clog2(ENTRY_W / 8),
  localparam int PA_W   = PPN_W + IDX_W + ENT_SH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic               req_user,
  input  logic [PPN_W-1:0]   req_root_ppn,
  output logic               mem_req_valid,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               rsp_valid,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic               rsp_readonly,
  output logic               rsp_user,
  output logic               rsp_fault
);
  logic             idle, start, issue, take, finish, done;
  logic [LVL_W-1:0] level;
  logic             present, ro_now, usr_now;
  logic [PPN_W-1:0] next_ppn;

  logic [VPN_W-1:0] vpn_q;
  logic             user_q;
  logic [PPN_W-1:0] tbl_q;

  pgwalk_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mem_rsp_valid(mem_rsp_valid),
    .present(present), .idle(idle), .start(start), .issue(issue), .take(take),
    .finish(finish), .done(done), .level(level)
  );

  pgwalk_addr #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .ENT_SH(ENT_SH)) u_addr (
    .vpn(vpn_q), .level(level), .table_ppn(tbl_q), .entry_addr(mem_req_addr)
  );

  pgwalk_attr #(.ENTRY_W(ENTRY_W), .PPN_W(PPN_W)) u_attr (
    .clk(clk), .rst(rst), .clear(start), .load(take), .entry(mem_rsp_data),
    .present(present), .next_ppn(next_ppn), .ro_now(ro_now), .usr_now(usr_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_q  <= '0;
      user_q <= 1'b0;
      tbl_q  <= '0;
    end else if (start) begin
      vpn_q  <= req_vpn;
      user_q <= req_user;
      tbl_q  <= req_root_ppn;
    end else if (take) begin
      tbl_q  <= next_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ppn      <= '0;
      rsp_readonly <= 1'b0;
      rsp_user     <= 1'b0;
      rsp_fault    <= 1'b0;
    end else if (finish) begin
      rsp_ppn      <= next_ppn;
      rsp_readonly <= ro_now;
      rsp_user     <= usr_now;
      rsp_fault    <= !present || (user_q && !usr_now);
    end
  end

  assign req_ready     = idle;
  assign mem_req_valid = issue;
  assign rsp_valid     = done;
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int LEVELS = pgwalk_pkg::LEVELS
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic mem_req_valid,
  input logic rsp_valid
);
  localparam int CNT_W = $clog2(LEVELS + 1) + 1;
  logic [CNT_W-1:0] reads;

  always_ff @(posedge clk) begin
    if (rst || (req_valid && req_ready)) reads <= '0;
    else if (mem_req_valid)             reads <= reads + 1'b1;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (req_ready && !mem_req_valid && !rsp_valid));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_no_read_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  p_read_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  p_read_limit_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (reads < CNT_W'(LEVELS)));

  p_result_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_result_not_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!req_ready && !mem_req_valid));
endmodule

bind pgwalk_top pgwalk_chk #(.LEVELS(LEVELS)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .rsp_valid(rsp_valid)
);

// File: tb/tb_pgwalk_top.sv
module tb_pgwalk_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        req_valid, req_ready, req_user;
  logic [35:0] req_vpn;
  logic [39:0] req_root_ppn;
  logic        mem_req_valid, mem_rsp_valid;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_readonly, rsp_user, rsp_fault;
  logic [39:0] rsp_ppn;

  pgwalk_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_user(req_user), .req_root_ppn(req_root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ppn(rsp_ppn), .rsp_readonly(rsp_readonly),
    .rsp_user(rsp_user), .rsp_fault(rsp_fault)
  );

  // vector: {vaddr[47:0], user, root_ppn[39:0], flags[11:0]}
  // flags: 3 bits per level, level 0 lowest, each {user, write, present}
  localparam int NV = 8;
  localparam logic [100:0] VEC [NV] = '{
    {48'h0000_0000_1000, 1'b0, 40'h00_0000_0100, 12'hFFF},
    {48'hFFFF_FFFF_F000, 1'b1, 40'hAB_CDEF_0123, 12'hFFF},
    {48'h1234_5678_9ABC, 1'b1, 40'h12_3456_789A, 12'hF7F},
    {48'h7FFF_0000_0000, 1'b1, 40'h00_0F00_0000, 12'hFFE},
    {48'h8000_4020_1000, 1'b0, 40'h55_5555_5555, 12'hDFF},
    {48'h0040_2010_0000, 1'b1, 40'h00_0000_0001, 12'hFDF},
    {48'h0040_2010_0000, 1'b0, 40'h00_0000_0001, 12'hFDF},
    {48'hABCD_EF01_2345, 1'b0, 40'hFF_FFFF_FFFF, 12'hE3F}
  };

  int passed = 0;
  int total  = 0;
  int cur    = 0;
  int reads  = 0;
  int mk;
  logic [51:0] ma;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  function automatic logic [39:0] ppn_of(input int i, input int k);
    return 40'h3_0000_0000 + 40'(i * 64 + k * 4 + 1);
  endfunction

  function automatic logic [2:0] fl(input int i, input int k);
    return VEC[i][3*k +: 3];
  endfunction

  function automatic logic [63:0] entry_of(input int i, input int k);
    return {12'hA5C, ppn_of(i, k), 9'h155, fl(i, k)};
  endfunction

  function automatic logic [51:0] exp_addr(input int i, input int k);
    logic [39:0] p;
    logic [47:0] va;
    va = VEC[i][100:53];
    p  = (k == 0) ? VEC[i][51:12] : ppn_of(i, k - 1);
    return {p, va[12 + (3 - k) * 9 +: 9], 3'b000};
  endfunction

  // memory model: answers each read after 1..3 cycles, checks its address
  initial begin
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        mk = reads;
        ma = mem_req_addr;
        reads++;
        if (mk < 4) check(ma == exp_addr(cur, mk), "R3", "entry address", 64'(ma), 64'(exp_addr(cur, mk)));
        else        check(1'b0, "R4", "read beyond leaf", 64'(mk), 64'd3);
        repeat (1 + (cur % 3)) @(negedge clk);
        mem_rsp_data  = entry_of(cur, (mk < 4) ? mk : 3);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  task automatic run_walk(input int i, input bit scramble);
    logic [47:0] va;
    int fnp, exp_reads, w;
    bit ro, usr, flt;
    va  = VEC[i][100:53];
    cur = i;
    reads = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready before walk", 64'(req_ready), 64'd1);
    req_valid    = 1'b1;
    req_vpn      = va[47:12];
    req_user     = VEC[i][52];
    req_root_ppn = VEC[i][51:12];
    @(negedge clk);
    if (scramble) begin
      req_vpn      = ~req_vpn;
      req_root_ppn = ~req_root_ppn;
      req_user     = ~req_user;
    end else begin
      req_valid = 1'b0;
    end
    w = 0;
    while (!rsp_valid && w < 400) begin
      @(negedge clk);
      w++;
    end
    req_valid = 1'b0;
    fnp = 4; ro = 1'b0; usr = 1'b1;
    for (int k = 3; k >= 0; k--) if (!fl(i, k)[0]) fnp = k;
    for (int k = 0; k < 4; k++) begin
      ro  = ro | ~fl(i, k)[1];
      usr = usr & fl(i, k)[2];
    end
    exp_reads = (fnp < 4) ? fnp + 1 : 4;
    flt = (fnp < 4) || (VEC[i][52] && !usr);
    check(rsp_valid == 1'b1, "R9", $sformatf("result pulse v%0d", i), 64'(rsp_valid), 64'd1);
    check(reads == exp_reads, (fnp < 4) ? "R5" : "R4", $sformatf("read count v%0d", i),
          64'(reads), 64'(exp_reads));
    check(rsp_fault == flt, (fnp < 4) ? "R5" : "R7", $sformatf("fault v%0d", i),
          64'(rsp_fault), 64'(flt));
    if (!flt) begin
      check(rsp_ppn == ppn_of(i, 3), "R8", $sformatf("ppn v%0d", i), 64'(rsp_ppn), 64'(ppn_of(i, 3)));
      check(rsp_readonly == ro, "R6", $sformatf("readonly v%0d", i), 64'(rsp_readonly), 64'(ro));
      check(rsp_user == usr, "R7", $sformatf("user flag v%0d", i), 64'(rsp_user), 64'(usr));
    end
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9", "pulse one cycle", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R9", "ready after result", 64'(req_ready), 64'd1);
    if (scramble)
      check(reads == exp_reads, "R2", "busy request ignored", 64'(reads), 64'(exp_reads));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vpn = '0; req_user = 1'b0; req_root_ppn = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
    check(mem_req_valid == 1'b0, "R1", "no read in reset", 64'(mem_req_valid), 64'd0);
    check(rsp_valid == 1'b0, "R1", "no result in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1 && !rsp_valid, "R1", "idle after release", 64'(req_ready), 64'd1);

    for (int i = 0; i < NV; i++) run_walk(i, i[0]);

    // reset during a walk: abandoned, no result, then a normal walk works
    cur = 4; reads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VEC[4][100:65]; req_user = 1'b0; req_root_ppn = VEC[4][51:12];
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after mid-walk reset", 64'(req_ready), 64'd1);
    begin
      bit seen;
      seen = 1'b0;
      repeat (10) begin
        @(negedge clk);
        if (rsp_valid) seen = 1'b1;
      end
      check(!seen, "R1", "no result from abandoned walk", 64'(seen), 64'd0);
    end
    run_walk(2, 1'b0);

    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule